// File: doc/BRIEF.md
# Quadrature Step Decoder and Position Counter

This block turns the two phase-shifted square waves of an incremental rotary encoder into a signed shaft position. Each raw channel first passes through a configurable synchronizer chain. It then goes through a pair of sample registers that hold the present and the previous sample. A change on either channel produces a single-clock count strobe, so one full electrical cycle of the encoder yields four counts. A direction bit is formed at the same time, and the strobe and direction bit together step an up/down counter that wraps.

All logic runs on one clock, which must be much faster than either channel can toggle. If both channels change within the same clock, no valid quadrature step can be inferred. In that case the count is left alone and a sticky error flag is raised. A synchronous reset clears the counter and the flag, and loads every sample register with the present input levels. This prevents a spurious count when reset is released with the encoder resting on a high level.

Top module: `quad_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `position` becomes 0, `step_err` becomes 0 and all sample registers take the present levels of `lead_in` and `lag_in`. With the inputs held steady, no strobe follows the release of reset, even when both inputs are 1.
- R2: A level change on one channel, first captured at rising edge k, makes `cnt_en` high for exactly one clock, from edge k+SYNC_STAGES until edge k+SYNC_STAGES+1.
- R3: One full encoder cycle (four single-channel changes) gives exactly four strobes and moves `position` by four.
- R4: While `cnt_en` is high, `dir_up` equals the present lead sample XOR the previous lag sample. It is 1 for the sequence (lead,lag) = 00,10,11,01,00 and 0 for the reverse sequence.
- R5: A strobe with `dir_up` = 1 adds 1 to `position` at the next rising edge.
- R6: A strobe with `dir_up` = 0 subtracts 1 from `position` at the next rising edge.
- R7: `position` is a POS_W-bit two's-complement value that wraps. It goes from the largest positive value to the most negative one when counting up, and from 0 to all ones when counting down.
- R8: `position` holds its value in every clock without a strobe.
- R9: When both channels change in the same sampled clock, no strobe is issued, `position` stays the same and `step_err` is set.
- R10: `step_err` stays high until the next reset.
- R11: Reversing direction in the middle of a cycle loses no count: N forward steps followed by N backward steps return `position` to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by all logic |
| rst | input | 1 | Synchronous reset, active high |
| lead_in | input | 1 | Raw leading encoder channel, asynchronous |
| lag_in | input | 1 | Raw lagging encoder channel, asynchronous |
| cnt_en | output | 1 | One-clock count strobe per detected edge |
| dir_up | output | 1 | Step direction, 1 = up, valid with `cnt_en` |
| position | output | POS_W | Signed position count |
| step_err | output | 1 | Sticky flag for a simultaneous change on both channels |

## Verification
The bench builds the decoder with POS_W = 8 and SYNC_STAGES = 2. The narrow counter brings both wrap boundaries within a few hundred clocks: 127 to -128 going up and 0 to -1 going down. The two-stage chain makes the strobe latency depend on the parameter rather than on a fixed single stage. Directed tasks step both rotation directions, reverse in mid-cycle, force an illegal double change, and check that the error flag stays high until a reset that is applied with both inputs held high.

// File: rtl/qd_pkg.sv
package qd_pkg;

    localparam int NUM_CH = 2;

    typedef enum int {
        CH_LEAD = 0,
        CH_LAG  = 1
    } qd_chan_e;

    // Result of one clock of step decoding
    typedef struct packed {
        logic en;     // exactly one channel moved
        logic up;     // direction of that move
        logic clash;  // both channels moved together
    } qd_step_t;

endpackage

// File: rtl/qd_chan_sampler.sv
module qd_chan_sampler #(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic cur,
    output logic dly
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   cur;
        logic                   dly;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sync = {SYNC_STAGES{raw}};
            st_d.cur  = raw;
            st_d.dly  = raw;
        end else begin
            st_d.sync[0] = raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                st_d.sync[i] = st_q.sync[i-1];
            end
            st_d.cur = st_q.sync[SYNC_STAGES-1];
            st_d.dly = st_q.cur;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur = st_q.cur;
    assign dly = st_q.dly;

endmodule

// File: rtl/qd_step_decode.sv
module qd_step_decode
    import qd_pkg::*;
(
    input  logic     lead_cur,
    input  logic     lead_dly,
    input  logic     lag_cur,
    input  logic     lag_dly,
    output qd_step_t step
);

    logic lead_moved;
    logic lag_moved;

    always_comb begin
        lead_moved = lead_cur ^ lead_dly;
        lag_moved  = lag_cur ^ lag_dly;
        step.en    = lead_moved ^ lag_moved;
        step.up    = lead_cur ^ lag_dly;
        step.clash = lead_moved & lag_moved;
    end

endmodule

// File: rtl/qd_pos_counter.sv
module qd_pos_counter
    import qd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qd_step_t         step,
    output logic [POS_W-1:0] position,
    output logic             err
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             err;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pos = '0;
            st_d.err = 1'b0;
        end else begin
            if (step.en) begin
                st_d.pos = step.up ? st_q.pos + ONE : st_q.pos - ONE;
            end
            if (step.clash) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign position = st_q.pos;
    assign err      = st_q.err;

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qd_pkg::*;
#(
    parameter int POS_W       = 16,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lead_in,
    input  logic             lag_in,
    output logic             cnt_en,
    output logic             dir_up,
    output logic [POS_W-1:0] position,
    output logic             step_err
);

    logic [NUM_CH-1:0] raw_ch;
    logic [NUM_CH-1:0] cur_ch;
    logic [NUM_CH-1:0] dly_ch;
    qd_step_t          step;

    assign raw_ch[CH_LEAD] = lead_in;
    assign raw_ch[CH_LAG]  = lag_in;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qd_chan_sampler #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_smp (
            .clk(clk),
            .rst(rst),
            .raw(raw_ch[c]),
            .cur(cur_ch[c]),
            .dly(dly_ch[c])
        );
    end

    qd_step_decode u_dec (
        .lead_cur(cur_ch[CH_LEAD]),
        .lead_dly(dly_ch[CH_LEAD]),
        .lag_cur (cur_ch[CH_LAG]),
        .lag_dly (dly_ch[CH_LAG]),
        .step    (step)
    );

    qd_pos_counter #(
        .POS_W(POS_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .position(position),
        .err     (step_err)
    );

    assign cnt_en = step.en;
    assign dir_up = step.up;

endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk #(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             dir_up,
    input logic [POS_W-1:0] position,
    input logic             step_err
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    // R1: reset clears count and flag
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (position == '0) && !step_err);

    // R5: up step
    a_r5_count_up: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up) |=> position == $past(position) + ONE);

    // R6: down step
    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_up) |=> position == $past(position) - ONE);

    // R8: no strobe, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(position));

    // R10: error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        step_err |=> step_err);

    // R9: flag raised on a clash leaves the count alone
    a_r9_clash_no_count: assert property (@(posedge clk) disable iff (rst)
        $rose(step_err) |-> $stable(position));

endmodule

bind quad_decoder quad_decoder_chk #(
    .POS_W(POS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .dir_up  (dir_up),
    .position(position),
    .step_err(step_err)
);

// File: tb/quad_decoder_test.sv
module quad_decoder_test;

    localparam int CLK_PERIOD  = 10;
    localparam int POS_W       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int WATCHDOG    = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lead_in = 1'b0;
    logic             lag_in = 1'b0;
    logic             cnt_en;
    logic             dir_up;
    logic [POS_W-1:0] position;
    logic             step_err;

    int n_run  = 0;
    int n_fail = 0;
    int model  = 0;
    bit done   = 1'b0;

    quad_decoder #(
        .POS_W(POS_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .lead_in (lead_in),
        .lag_in  (lag_in),
        .cnt_en  (cnt_en),
        .dir_up  (dir_up),
        .position(position),
        .step_err(step_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [POS_W-1:0] exp_pos();
        return POS_W'(model);
    endfunction

    // Move to the given levels and check strobe, direction and count
    task automatic move(input logic a, input logic b, input logic up, input string req);
        @(negedge clk);
        lead_in = a;
        lag_in  = b;
        repeat (SYNC_STAGES) begin
            @(negedge clk);
            check(cnt_en == 1'b0, {req, " strobe too early"}, cnt_en, 0);
        end
        @(negedge clk);
        check(cnt_en == 1'b1, {req, " R2 strobe"}, cnt_en, 1);
        check(dir_up == up, {req, " R4 direction"}, dir_up, up);
        model = up ? model + 1 : model - 1;
        @(negedge clk);
        check(cnt_en == 1'b0, {req, " R2 strobe one clock"}, cnt_en, 0);
        check(position == exp_pos(), {req, " position"}, position, exp_pos());
    endtask

    task automatic fwd(input string req);
        if (lead_in == lag_in) move(~lead_in, lag_in, 1'b1, req);
        else                   move(lead_in, ~lag_in, 1'b1, req);
    endtask

    task automatic rev(input string req);
        if (lead_in == lag_in) move(lead_in, ~lag_in, 1'b0, req);
        else                   move(~lead_in, lag_in, 1'b0, req);
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst     = 1'b1;
        lead_in = a;
        lag_in  = b;
        repeat (3) @(negedge clk);
        rst   = 1'b0;
        model = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b1);
        check(position == '0, "R1 position cleared", position, 0);
        check(step_err == 1'b0, "R1 error cleared", step_err, 0);
        for (int i = 0; i < SYNC_STAGES + 4; i++) begin
            @(negedge clk);
            check(cnt_en == 1'b0, "R1 no strobe after reset", cnt_en, 0);
        end
        check(position == '0, "R1 R8 position held", position, 0);
    endtask

    task automatic t_forward();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) fwd("R3 R5 forward");
        check(position == POS_W'(4), "R3 four counts per cycle", position, 4);
        check(lead_in == 1'b0 && lag_in == 1'b0, "R3 cycle closed", {lead_in, lag_in}, 0);
    endtask

    task automatic t_reverse();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) rev("R6 reverse");
        check(position == POS_W'(-4), "R3 R6 minus four", position, -4);
    endtask

    task automatic t_reversal();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) fwd("R11 out");
        for (int i = 0; i < 3; i++) rev("R11 back");
        check(position == '0, "R11 back to start", position, 0);
        fwd("R11 single");
        rev("R11 single back");
        check(position == '0, "R11 one-step reversal", position, 0);
    endtask

    task automatic t_wrap();
        do_reset(1'b0, 1'b0);
        rev("R7 down wrap");
        check(position == '1, "R7 zero to all ones", position, -1);
        for (int i = 0; i < 128; i++) fwd("R7 climb");
        check(position == POS_W'(127), "R7 max positive", position, 127);
        fwd("R7 up wrap");
        check(position == {1'b1, {(POS_W-1){1'b0}}}, "R7 wrap to most negative", position, -128);
    endtask

    task automatic t_clash();
        logic [POS_W-1:0] held;
        do_reset(1'b0, 1'b0);
        fwd("R9 setup");
        held = position;
        @(negedge clk);
        lead_in = ~lead_in;
        lag_in  = ~lag_in;
        repeat (SYNC_STAGES + 1) @(negedge clk);
        check(cnt_en == 1'b0, "R9 no strobe on clash", cnt_en, 0);
        @(negedge clk);
        check(step_err == 1'b1, "R9 error set", step_err, 1);
        check(position == held, "R9 count unchanged", position, held);
        fwd("R10 legal after clash");
        rev("R10 legal after clash");
        check(step_err == 1'b1, "R10 error sticky", step_err, 1);
        do_reset(1'b1, 1'b1);
        check(step_err == 1'b0, "R10 reset clears error", step_err, 0);
        repeat (SYNC_STAGES + 3) @(negedge clk);
        check(cnt_en == 1'b0 && position == '0, "R1 quiet after reset high", position, 0);
    endtask

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_reversal();
        t_wrap();
        t_clash();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule